// File: doc/BRIEF.md
# Punctuation-Closed Sliding-Window Aggregation Slot

This block is one slot of a bank of overlapping time windows that aggregate a stream of tuples. Each slot holds the lower and upper timestamp bounds of the window it currently covers. Every tuple on the input bus is tested against those bounds in the cycle it arrives. A tuple that falls inside the window updates a running count, a running sum, a minimum and a maximum of its value field. Because membership depends only on the tuple's own timestamp, tuples may arrive in any order.

A window is closed only by a punctuation: a bus word that marks a timestamp below which no further tuples will arrive. When a punctuation's timestamp reaches the slot's upper bound, the slot raises its close strobe in the same cycle. On the next cycle it presents the finished aggregates together with the window's upper bound. It then clears its accumulators and moves both bounds forward by the width of the whole bank (slot count times slide step), so it is ready to cover a later window. Several slots with consecutive indices share one input bus; merging their results is handled outside this block.

Top module: `swin_slot`

## Requirements
- R1: After reset, a slot with 1-based index SLOT_IDX covers timestamps t with T_START+(SLOT_IDX-1)*STEP <= t < T_START+(SLOT_IDX-1)*STEP+SPAN, all as unsigned 32-bit values.
- R2: A tuple (tupValid=1, punctIn=0) is admitted to the aggregates only when its attrIn lies inside the current bounds. A word with tupValid=0, or with punctIn=1, is never admitted.
- R3: winClose is combinational and equals 1 exactly when punctIn=1 and attrIn >= the current upper bound. It is 0 whenever punctIn=0.
- R4: On each clock edge where winClose=1, both bounds advance by SLOT_COUNT*STEP.
- R5: Each admitted tuple adds 1 to the count and valIn to the sum, which is 32 bits wide and wraps on overflow. It lowers the minimum to valIn if valIn is smaller, and raises the maximum to valIn if valIn is larger.
- R6: In the cycle after a close, resValid=1 and resCount, resSum, resMin and resMax hold the aggregates as they stood before the close, with resEnd holding the upper bound that was closed. At all other times resValid=0.
- R7: After a close, the aggregates restart from count 0, sum 0, minimum 0xFFFFFFFF and maximum 0. A window closed with no admitted tuples therefore reports exactly these values.
- R8: A punctuation with attrIn below the upper bound changes neither the bounds nor the aggregates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| attrIn | input | 32 | Timestamp of the current bus word |
| valIn | input | 32 | Value field that is aggregated |
| tupValid | input | 1 | Bus word is a tuple |
| punctIn | input | 1 | Bus word is a punctuation |
| winClose | output | 1 | Current punctuation closes this window |
| resValid | output | 1 | Result fields hold a finished window |
| resCount | output | 32 | Number of tuples admitted to the closed window |
| resSum | output | 32 | Wrapped sum of their values |
| resMin | output | 32 | Smallest value admitted |
| resMax | output | 32 | Largest value admitted |
| resEnd | output | 32 | Upper bound of the closed window |

## Verification
The hardest state to reach is the second and third life of the slot. Only after a close with the right timestamp does the slot cover a window it never started in. Checking that window needs both an exact advance of the bounds and a clean reload of the aggregates. The stimulus table therefore drives three windows in a row. Inside each window it places tuples on both bounds and one step outside them, out of timestamp order, and punctuations just below and at the bound. It also closes one window with no tuples and one with a sum that wraps, so that the reload values and the wrap both show at the result port.

// File: rtl/swin_pkg.sv
package swin_pkg;
  localparam int TS_W  = 32;
  localparam int VAL_W = 32;
  localparam int CNT_W = 32;

  // strobes from window control to the aggregation datapath
  typedef struct packed {
    logic admit;
    logic close;
  } swin_strobe_t;

  typedef struct packed {
    logic [CNT_W-1:0] count;
    logic [VAL_W-1:0] sum;
    logic [VAL_W-1:0] minVal;
    logic [VAL_W-1:0] maxVal;
  } swin_agg_t;

  localparam swin_agg_t AGG_EMPTY = '{count: '0, sum: '0, minVal: '1, maxVal: '0};
endpackage

// File: rtl/swin_ctrl.sv
module swin_ctrl
  import swin_pkg::*;
#(
  parameter int unsigned SLOT_IDX   = 1,
  parameter int unsigned T_START    = 0,
  parameter int unsigned SPAN       = 600,
  parameter int unsigned STEP       = 60,
  parameter int unsigned SLOT_COUNT = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TS_W-1:0] attrIn,
  input  logic            tupValid,
  input  logic            punctIn,
  output swin_strobe_t    strobe,
  output logic [TS_W-1:0] winEnd
);
  localparam logic [TS_W-1:0] BEGIN_INIT = TS_W'(T_START + (SLOT_IDX - 1) * STEP);
  localparam logic [TS_W-1:0] END_INIT   = BEGIN_INIT + TS_W'(SPAN);
  localparam logic [TS_W-1:0] ADVANCE    = TS_W'(SLOT_COUNT * STEP);

  logic [TS_W-1:0] winBegin;
  logic            atOrPastEnd;
  logic            insideWin;

  assign atOrPastEnd = (attrIn >= winEnd);
  assign insideWin   = (attrIn >= winBegin) && !atOrPastEnd;

  always_comb begin
    strobe.close = punctIn && atOrPastEnd;
    strobe.admit = !punctIn && tupValid && insideWin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      winBegin <= BEGIN_INIT;
      winEnd   <= END_INIT;
    end else if (strobe.close) begin
      winBegin <= winBegin + ADVANCE;
      winEnd   <= winEnd + ADVANCE;
    end
  end
endmodule

// File: rtl/swin_accum.sv
module swin_accum
  import swin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  swin_strobe_t     strobe,
  input  logic [VAL_W-1:0] valIn,
  input  logic [TS_W-1:0]  winEnd,
  output logic [CNT_W-1:0] runCount,
  output logic             resValid,
  output swin_agg_t        result,
  output logic [TS_W-1:0]  resEnd
);
  swin_agg_t acc;
  swin_agg_t accNext;

  always_comb begin
    accNext        = acc;
    accNext.count  = acc.count + CNT_W'(1);
    accNext.sum    = acc.sum + valIn;
    if (valIn < acc.minVal) accNext.minVal = valIn;
    if (valIn > acc.maxVal) accNext.maxVal = valIn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc      <= AGG_EMPTY;
      result   <= '0;
      resEnd   <= '0;
      resValid <= 1'b0;
    end else begin
      resValid <= strobe.close;
      if (strobe.close) begin
        result <= acc;
        resEnd <= winEnd;
        acc    <= AGG_EMPTY;
      end else if (strobe.admit) begin
        acc <= accNext;
      end
    end
  end

  assign runCount = acc.count;
endmodule

// File: rtl/swin_slot.sv
module swin_slot
  import swin_pkg::*;
#(
  parameter int unsigned SLOT_IDX   = 1,
  parameter int unsigned T_START    = 0,
  parameter int unsigned SPAN       = 600,
  parameter int unsigned STEP       = 60,
  parameter int unsigned SLOT_COUNT = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TS_W-1:0]  attrIn,
  input  logic [VAL_W-1:0] valIn,
  input  logic             tupValid,
  input  logic             punctIn,
  output logic             winClose,
  output logic             resValid,
  output logic [CNT_W-1:0] resCount,
  output logic [VAL_W-1:0] resSum,
  output logic [VAL_W-1:0] resMin,
  output logic [VAL_W-1:0] resMax,
  output logic [TS_W-1:0]  resEnd
);
  swin_strobe_t    strobe;
  logic [TS_W-1:0] ctrlEnd;
  logic [CNT_W-1:0] runCount;
  swin_agg_t       result;

  swin_ctrl #(
    .SLOT_IDX(SLOT_IDX), .T_START(T_START), .SPAN(SPAN),
    .STEP(STEP), .SLOT_COUNT(SLOT_COUNT)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .attrIn(attrIn), .tupValid(tupValid),
    .punctIn(punctIn), .strobe(strobe), .winEnd(ctrlEnd)
  );

  swin_accum u_accum (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .valIn(valIn),
    .winEnd(ctrlEnd), .runCount(runCount), .resValid(resValid),
    .result(result), .resEnd(resEnd)
  );

  assign winClose = strobe.close;
  assign resCount = result.count;
  assign resSum   = result.sum;
  assign resMin   = result.minVal;
  assign resMax   = result.maxVal;
endmodule

// File: rtl/swin_slot_chk.sv
module swin_slot_chk #(
  parameter int unsigned STEP       = 60,
  parameter int unsigned SLOT_COUNT = 11
) (
  input logic        clk,
  input logic        rst_n,
  input logic        punctIn,
  input logic        winClose,
  input logic        resValid,
  input logic [31:0] ctrlEnd,
  input logic [31:0] runCount
);
  localparam logic [31:0] ADVANCE = 32'(SLOT_COUNT * STEP);

  assert_close_needs_punct_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !punctIn |-> !winClose);

  assert_result_follows_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
    winClose |=> resValid);

  assert_result_only_after_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !winClose |=> !resValid);

  assert_bounds_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    winClose |=> (ctrlEnd == $past(ctrlEnd) + ADVANCE));

  assert_bounds_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !winClose |=> $stable(ctrlEnd));

  assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    winClose |=> (runCount == 32'd0));

  assert_punct_no_admit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (punctIn && !winClose) |=> $stable(runCount));

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !punctIn |=> (runCount == $past(runCount) || runCount == $past(runCount) + 32'd1));
endmodule

bind swin_slot swin_slot_chk #(.STEP(STEP), .SLOT_COUNT(SLOT_COUNT)) u_chk (
  .clk(clk), .rst_n(rst_n), .punctIn(punctIn), .winClose(winClose),
  .resValid(resValid), .ctrlEnd(ctrlEnd), .runCount(runCount)
);

// File: tb/swin_slot_bench.sv
module swin_slot_bench;
  // slot 2 of 11, start 1000, span 600, step 60:
  // windows [1060,1660) -> [1720,2320) -> [2380,2980)
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] attrIn = '0;
  logic [31:0] valIn = '0;
  logic tupValid = 1'b0;
  logic punctIn = 1'b0;
  logic winClose, resValid;
  logic [31:0] resCount, resSum, resMin, resMax, resEnd;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  swin_slot #(
    .SLOT_IDX(2), .T_START(1000), .SPAN(600), .STEP(60), .SLOT_COUNT(11)
  ) u_swin_slot (
    .clk(clk), .rst_n(rst_n), .attrIn(attrIn), .valIn(valIn),
    .tupValid(tupValid), .punctIn(punctIn), .winClose(winClose),
    .resValid(resValid), .resCount(resCount), .resSum(resSum),
    .resMin(resMin), .resMax(resMax), .resEnd(resEnd)
  );

  typedef struct packed {
    logic        punct;
    logic        valid;
    logic [31:0] attr;
    logic [31:0] val;
    logic        expClose;
    logic [31:0] expCount;
    logic [31:0] expSum;
    logic [31:0] expMin;
    logic [31:0] expMax;
    logic [31:0] expEnd;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b1, 32'd1100, 32'd5,   1'b0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0},
    '{1'b0, 1'b1, 32'd1659, 32'd9,   1'b0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0},
    '{1'b0, 1'b1, 32'd1660, 32'd100, 1'b0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0},
    '{1'b0, 1'b1, 32'd1059, 32'd100, 1'b0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0},
    '{1'b0, 1'b1, 32'd1060, 32'd2,   1'b0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0},
    '{1'b0, 1'b0, 32'd1200, 32'd100, 1'b0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0},
    '{1'b1, 1'b0, 32'd1500, 32'd0,   1'b0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0},
    '{1'b1, 1'b1, 32'd1200, 32'd100, 1'b0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0},
    '{1'b0, 1'b1, 32'd1300, 32'd7,   1'b0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0},
    '{1'b1, 1'b0, 32'd1660, 32'd0,   1'b1, 32'd4, 32'd23, 32'd2, 32'd9, 32'd1660},
    '{1'b1, 1'b0, 32'd2000, 32'd0,   1'b0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0},
    '{1'b1, 1'b0, 32'd2320, 32'd0,   1'b1, 32'd0, 32'd0, 32'hFFFF_FFFF, 32'd0, 32'd2320},
    '{1'b0, 1'b1, 32'd2500, 32'hFFFF_FFFF, 1'b0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0},
    '{1'b0, 1'b1, 32'd2979, 32'd3,   1'b0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0},
    '{1'b0, 1'b1, 32'd2400, 32'd0,   1'b0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0},
    '{1'b1, 1'b0, 32'd5000, 32'd0,   1'b1, 32'd3, 32'd2, 32'd0, 32'hFFFF_FFFF, 32'd2980}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic driveWord(input logic p, input logic v,
                           input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    punctIn = p; tupValid = v; attrIn = a; valIn = d;
  endtask

  // close strobe is sampled before the edge, results one edge later
  task automatic applyVec(input vec_t vc, input int idx);
    driveWord(vc.punct, vc.valid, vc.attr, vc.val);
    #2;
    check("R3", $sformatf("winClose row %0d", idx), 32'(winClose), 32'(vc.expClose));
    @(posedge clk);
    #2;
    check("R6", $sformatf("resValid row %0d", idx), 32'(resValid), 32'(vc.expClose));
    if (vc.expClose) begin
      check("R5", $sformatf("resCount row %0d", idx), resCount, vc.expCount);
      check("R5", $sformatf("resSum row %0d", idx), resSum, vc.expSum);
      check("R7", $sformatf("resMin row %0d", idx), resMin, vc.expMin);
      check("R5", $sformatf("resMax row %0d", idx), resMax, vc.expMax);
      check("R4", $sformatf("resEnd row %0d", idx), resEnd, vc.expEnd);
    end
  endtask

  function automatic vec_t mk(input logic p, input logic v, input logic [31:0] a,
                              input logic [31:0] d, input logic c,
                              input logic [31:0] n, input logic [31:0] s,
                              input logic [31:0] mn, input logic [31:0] mx,
                              input logic [31:0] e);
    vec_t r;
    r = '{p, v, a, d, c, n, s, mn, mx, e};
    return r;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R6", "resValid in reset", 32'(resValid), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    check("R3", "winClose idle", 32'(winClose), 32'd0);

    // main table: rows 0-9 R1/R2 bounds, rows 6-7 R8, row 11 R7, row 15 R5 wrap
    for (int i = 0; i < NVEC; i++) applyVec(VECS[i], i);

    // slot now covers [3040,3640): a punctuation at old bound must not close (R4)
    applyVec(mk(1'b1, 1'b0, 32'd2980, 32'd0, 1'b0, 0, 0, 0, 0, 0), 100);
    applyVec(mk(1'b0, 1'b1, 32'd3040, 32'd11, 1'b0, 0, 0, 0, 0, 0), 101);
    applyVec(mk(1'b1, 1'b0, 32'd3640, 32'd0, 1'b1, 32'd1, 32'd11, 32'd11, 32'd11, 32'd3640), 102);

    // reset mid-window restores the initial bounds (R1)
    applyVec(mk(1'b0, 1'b1, 32'd3800, 32'd6, 1'b0, 0, 0, 0, 0, 0), 103);
    @(negedge clk);
    punctIn = 1'b0; tupValid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    applyVec(mk(1'b0, 1'b1, 32'd1060, 32'd4, 1'b0, 0, 0, 0, 0, 0), 200);
    applyVec(mk(1'b1, 1'b0, 32'd1659, 32'd0, 1'b0, 0, 0, 0, 0, 0), 201);
    applyVec(mk(1'b1, 1'b0, 32'd1660, 32'd0, 1'b1, 32'd1, 32'd4, 32'd4, 32'd4, 32'd1660), 202);

    // result strobe lasts one cycle only (R6)
    driveWord(1'b0, 1'b0, 32'd0, 32'd0);
    @(posedge clk);
    #2;
    check("R6", "resValid drops after one cycle", 32'(resValid), 32'd0);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual running expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule